// File: doc/BRIEF.md
# Microprogram Sequencer with Return Stack

This block sequences a microprogrammed control unit. Each cycle it reads one word from an internal control store at the current micro-address. It drives that word's control bits onto its outputs and decides where the next micro-address comes from. The control store is a constant table built into the logic. Each word has three parts: a control word, a target address, and a 3-bit sequencing code. A separate bit in the word marks the last step of a routine.

The next address has several possible sources:
- the current address plus one;
- the target, taken only when the selected condition flag is true;
- an unconditional jump to the target;
- an opcode mapping step;
- a subroutine call or return through a small hardware return-address stack.

After reset the sequencer sits at address 0. The word there is a mapping step, and it waits for a start strobe before it dispatches to the routine of the presented opcode. Each opcode owns a four-word slot at `{opcode, 2'b00}`.

Top module: `useq_sequencer`

## Requirements
- R1: A synchronous active-high reset sets the micro-address to 0 and clears both sticky stack error flags (`stk_ovf`, `stk_unf`). After reset, address 0 presents control word 0x01 with `routine_end` low.
- R2: Address 0 holds a mapping word (sequencing code 100). While `start` is low the micro-address stays where it is, whatever the opcode. With `start` high the next micro-address is `{opcode, 2'b00}`.
- R3: Code 000 advances the micro-address by one. The opcode-1 routine steps 4, 5, 6 and then returns to 0.
- R4: Code 001 loads the target when `flag_z` is high and otherwise increments. The opcode-2 routine runs 8, 11, 0 with Zero set and 8, 9, 10, 0 with Zero clear.
- R5: Code 010 does the same on `flag_c`. The opcode-3 routine runs 12, 15, 0 with Carry set and 12, 13, 0 with Carry clear.
- R6: Code 011 always loads the target. Every routine ends with such a jump back to address 0.
- R7: Code 101 jumps to the target and pushes the call's own address plus one. Code 110 pops and resumes at the popped address, in last-in first-out order. The opcode-4 routine runs 16, 60, 61, 17, 0. The nested opcode-5 routine runs 20, 56, 60, 61, 57, 21, 0.
- R8: The stack holds four entries. A call with the stack full still jumps but does not push, and it sets `stk_ovf`, which stays set until reset. The opcode-7 routine calls itself at address 28, so `stk_ovf` rises on the fifth call, and the address stays 28.
- R9: A return with the stack empty goes to address 0 and sets `stk_unf`, which stays set until reset. The opcode-6 routine is a single return at address 24.
- R10: The control word and `routine_end` come combinationally from the word at the current micro-address, in the same cycle. Address 4 gives control word 0x10. Address 6 gives `routine_end` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start strobe that releases a mapping step |
| opcode | input | OP_W | Macro opcode used by the mapping step |
| flag_z | input | 1 | Zero condition flag |
| flag_c | input | 1 | Carry condition flag |
| uaddr | output | OP_W+2 | Current micro-address |
| ctrl | output | CW | Control word of the current microinstruction |
| routine_end | output | 1 | Current word is the last step of a routine |
| stk_ovf | output | 1 | Sticky return-stack overflow |
| stk_unf | output | 1 | Sticky return-stack underflow |

## Verification
The bench builds the block with its defaults: a 4-bit opcode, which gives a 64-word control store, an 8-bit control word and a four-entry return stack. With these values every opcode slot used by the stored program can be reached. A single self-calling routine fills the stack in four cycles, so the overflow corner is reached early, and the empty-stack return is one instruction away. Nested calls two deep show last-in first-out ordering in a short trace.

// File: rtl/useq_pkg.sv
package useq_pkg;
  typedef enum logic [2:0] {
    SQ_NEXT = 3'b000,
    SQ_BZ   = 3'b001,
    SQ_BC   = 3'b010,
    SQ_JMP  = 3'b011,
    SQ_MAP  = 3'b100,
    SQ_CALL = 3'b101,
    SQ_RET  = 3'b110,
    SQ_RSV  = 3'b111
  } seq_e;
endpackage

// File: rtl/useq_store.sv
// Constant control store, read combinationally. Program assumes OP_W >= 4.
module useq_store
  import useq_pkg::*;
#(
  parameter int OP_W = 4,
  parameter int CW   = 8,
  localparam int AW  = OP_W + 2
) (
  input  logic [AW-1:0] addr,
  output seq_e          seq,
  output logic [AW-1:0] tgt,
  output logic [CW-1:0] ctl,
  output logic          last
);
  always_comb begin
    seq  = SQ_JMP;
    tgt  = '0;
    ctl  = '0;
    last = 1'b1;
    case (int'(addr))
      // fetch: wait for start, then dispatch
      0:  begin seq = SQ_MAP;  tgt = '0;        ctl = CW'('h01); last = 1'b0; end
      // opcode 1: straight line
      4:  begin seq = SQ_NEXT; tgt = '0;        ctl = CW'('h10); last = 1'b0; end
      5:  begin seq = SQ_NEXT; tgt = '0;        ctl = CW'('h11); last = 1'b0; end
      6:  begin seq = SQ_JMP;  tgt = '0;        ctl = CW'('h12); last = 1'b1; end
      // opcode 2: branch on zero
      8:  begin seq = SQ_BZ;   tgt = AW'(11);   ctl = CW'('h20); last = 1'b0; end
      9:  begin seq = SQ_NEXT; tgt = '0;        ctl = CW'('h21); last = 1'b0; end
      10: begin seq = SQ_JMP;  tgt = '0;        ctl = CW'('h22); last = 1'b1; end
      11: begin seq = SQ_JMP;  tgt = '0;        ctl = CW'('h23); last = 1'b1; end
      // opcode 3: branch on carry
      12: begin seq = SQ_BC;   tgt = AW'(15);   ctl = CW'('h30); last = 1'b0; end
      13: begin seq = SQ_JMP;  tgt = '0;        ctl = CW'('h31); last = 1'b1; end
      15: begin seq = SQ_JMP;  tgt = '0;        ctl = CW'('h33); last = 1'b1; end
      // opcode 4: single call
      16: begin seq = SQ_CALL; tgt = AW'(60);   ctl = CW'('h40); last = 1'b0; end
      17: begin seq = SQ_JMP;  tgt = '0;        ctl = CW'('h41); last = 1'b1; end
      // opcode 5: nested call
      20: begin seq = SQ_CALL; tgt = AW'(56);   ctl = CW'('h50); last = 1'b0; end
      21: begin seq = SQ_JMP;  tgt = '0;        ctl = CW'('h51); last = 1'b1; end
      // opcode 6: return with nothing saved
      24: begin seq = SQ_RET;  tgt = '0;        ctl = CW'('h60); last = 1'b1; end
      // opcode 7: runaway self call
      28: begin seq = SQ_CALL; tgt = AW'(28);   ctl = CW'('h70); last = 1'b0; end
      // outer subroutine
      56: begin seq = SQ_CALL; tgt = AW'(60);   ctl = CW'('hE0); last = 1'b0; end
      57: begin seq = SQ_RET;  tgt = '0;        ctl = CW'('hE1); last = 1'b0; end
      // inner subroutine
      60: begin seq = SQ_NEXT; tgt = '0;        ctl = CW'('hF0); last = 1'b0; end
      61: begin seq = SQ_RET;  tgt = '0;        ctl = CW'('hF1); last = 1'b0; end
      default: begin seq = SQ_JMP; tgt = '0; ctl = '0; last = 1'b1; end
    endcase
  end
endmodule

// File: rtl/useq_next.sv
// Next-address selection and stack requests.
module useq_next
  import useq_pkg::*;
#(
  parameter int OP_W = 4,
  localparam int AW  = OP_W + 2
) (
  input  logic [AW-1:0]   pc,
  input  seq_e            seq,
  input  logic [AW-1:0]   tgt,
  input  logic            start,
  input  logic [OP_W-1:0] opcode,
  input  logic            fz,
  input  logic            fc,
  input  logic [AW-1:0]   stk_top,
  input  logic            stk_empty,
  input  logic            stk_full,
  output logic [AW-1:0]   pc_nxt,
  output logic [AW-1:0]   ret_addr,
  output logic            push,
  output logic            pop,
  output logic            set_ovf,
  output logic            set_unf
);
  logic [AW-1:0] inc;
  assign inc      = pc + AW'(1);
  assign ret_addr = inc;

  always_comb begin
    pc_nxt  = inc;
    push    = 1'b0;
    pop     = 1'b0;
    set_ovf = 1'b0;
    set_unf = 1'b0;
    case (seq)
      SQ_NEXT: pc_nxt = inc;
      SQ_BZ:   pc_nxt = fz ? tgt : inc;
      SQ_BC:   pc_nxt = fc ? tgt : inc;
      SQ_JMP:  pc_nxt = tgt;
      SQ_MAP:  pc_nxt = start ? {opcode, 2'b00} : pc;
      SQ_CALL: begin
        pc_nxt  = tgt;
        push    = !stk_full;
        set_ovf = stk_full;
      end
      SQ_RET: begin
        pc_nxt  = stk_empty ? '0 : stk_top;
        pop     = !stk_empty;
        set_unf = stk_empty;
      end
      default: pc_nxt = inc;
    endcase
  end
endmodule

// File: rtl/useq_stack.sv
// Return-address stack, DEPTH a power of two and at least 2.
module useq_stack #(
  parameter int DEPTH = 4,
  parameter int AW    = 6,
  localparam int IW   = $clog2(DEPTH),
  localparam int PW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic [AW-1:0] din,
  output logic [AW-1:0] top,
  output logic          empty,
  output logic          full,
  output logic [PW-1:0] cnt
);
  logic [AW-1:0] mem [DEPTH];
  logic [PW-1:0] cnt_m1;

  assign cnt_m1 = cnt - PW'(1);
  assign empty  = (cnt == '0);
  assign full   = (cnt == PW'(DEPTH));
  assign top    = empty ? '0 : mem[cnt_m1[IW-1:0]];

  always_ff @(posedge clk) begin
    if (push) mem[cnt[IW-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (push) cnt <= cnt + PW'(1);
    else if (pop)  cnt <= cnt_m1;
  end
endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
  import useq_pkg::*;
#(
  parameter int OP_W  = 4,
  parameter int CW    = 8,
  parameter int DEPTH = 4,
  localparam int AW   = OP_W + 2,
  localparam int PW   = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [OP_W-1:0] opcode,
  input  logic            flag_z,
  input  logic            flag_c,
  output logic [AW-1:0]   uaddr,
  output logic [CW-1:0]   ctrl,
  output logic            routine_end,
  output logic            stk_ovf,
  output logic            stk_unf
);
  logic [AW-1:0] pc, pc_nxt, tgt, stk_top, ret_addr;
  seq_e          cur_seq;
  logic          push, pop, set_ovf, set_unf, stk_empty, stk_full;
  logic [PW-1:0] stk_cnt;

  useq_store #(.OP_W(OP_W), .CW(CW)) u_store (
    .addr(pc), .seq(cur_seq), .tgt(tgt), .ctl(ctrl), .last(routine_end)
  );

  useq_next #(.OP_W(OP_W)) u_next (
    .pc(pc), .seq(cur_seq), .tgt(tgt), .start(start), .opcode(opcode),
    .fz(flag_z), .fc(flag_c), .stk_top(stk_top), .stk_empty(stk_empty),
    .stk_full(stk_full), .pc_nxt(pc_nxt), .ret_addr(ret_addr),
    .push(push), .pop(pop), .set_ovf(set_ovf), .set_unf(set_unf)
  );

  useq_stack #(.DEPTH(DEPTH), .AW(AW)) u_stack (
    .clk(clk), .rst(rst), .push(push), .pop(pop), .din(ret_addr),
    .top(stk_top), .empty(stk_empty), .full(stk_full), .cnt(stk_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc      <= '0;
      stk_ovf <= 1'b0;
      stk_unf <= 1'b0;
    end else begin
      pc <= pc_nxt;
      if (set_ovf) stk_ovf <= 1'b1;
      if (set_unf) stk_unf <= 1'b1;
    end
  end

  assign uaddr = pc;
endmodule

// File: rtl/useq_sequencer_chk.sv
module useq_sequencer_chk
  import useq_pkg::*;
#(
  parameter int OP_W  = 4,
  parameter int DEPTH = 4,
  localparam int AW   = OP_W + 2,
  localparam int PW   = $clog2(DEPTH + 1)
) (
  input logic            clk,
  input logic            rst,
  input logic            start,
  input logic [OP_W-1:0] opcode,
  input logic [AW-1:0]   uaddr,
  input seq_e            cur_seq,
  input logic [PW-1:0]   stk_cnt,
  input logic            stk_ovf,
  input logic            stk_unf
);
  // R2
  map_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cur_seq == SQ_MAP && !start) |=> $stable(uaddr));
  // R2
  map_go_chk: assert property (@(posedge clk) disable iff (rst)
    (cur_seq == SQ_MAP && start) |=> uaddr == {$past(opcode), 2'b00});
  // R3
  step_chk: assert property (@(posedge clk) disable iff (rst)
    (cur_seq == SQ_NEXT) |=> uaddr == AW'($past(uaddr) + 1'b1));
  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    stk_ovf |=> stk_ovf);
  // R8
  depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
    stk_cnt <= PW'(DEPTH));
  // R9
  unf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    stk_unf |=> stk_unf);
  // R9
  ret_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (cur_seq == SQ_RET && stk_cnt == '0) |=> (uaddr == '0 && stk_unf));
endmodule

bind useq_sequencer useq_sequencer_chk #(.OP_W(OP_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .start(start), .opcode(opcode), .uaddr(uaddr),
  .cur_seq(cur_seq), .stk_cnt(stk_cnt), .stk_ovf(stk_ovf), .stk_unf(stk_unf)
);

// File: tb/useq_sequencer_tb.sv
`timescale 1ns/1ps
module useq_sequencer_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [3:0] opcode = '0;
  logic       flag_z = 1'b0;
  logic       flag_c = 1'b0;
  logic [5:0] uaddr;
  logic [7:0] ctrl;
  logic       routine_end, stk_ovf, stk_unf;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  useq_sequencer u_dut (
    .clk(clk), .rst(rst), .start(start), .opcode(opcode),
    .flag_z(flag_z), .flag_c(flag_c), .uaddr(uaddr), .ctrl(ctrl),
    .routine_end(routine_end), .stk_ovf(stk_ovf), .stk_unf(stk_unf)
  );

  // {opcode, z, c, seven addresses seen after each clock from the start step}
  localparam logic [47:0] VEC [7] = '{
    {4'd1, 1'b0, 1'b0, 6'd4,  6'd5,  6'd6,  6'd0,  6'd0,  6'd0,  6'd0},  // R3 R6
    {4'd2, 1'b1, 1'b0, 6'd8,  6'd11, 6'd0,  6'd0,  6'd0,  6'd0,  6'd0},  // R4
    {4'd2, 1'b0, 1'b0, 6'd8,  6'd9,  6'd10, 6'd0,  6'd0,  6'd0,  6'd0},  // R4
    {4'd3, 1'b0, 1'b1, 6'd12, 6'd15, 6'd0,  6'd0,  6'd0,  6'd0,  6'd0},  // R5
    {4'd3, 1'b1, 1'b0, 6'd12, 6'd13, 6'd0,  6'd0,  6'd0,  6'd0,  6'd0},  // R5
    {4'd4, 1'b0, 1'b0, 6'd16, 6'd60, 6'd61, 6'd17, 6'd0,  6'd0,  6'd0},  // R7
    {4'd5, 1'b0, 1'b0, 6'd20, 6'd56, 6'd60, 6'd61, 6'd57, 6'd21, 6'd0}   // R7
  };

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    start = 1'b0;
    step();
    step();
    rst = 1'b0;
  endtask

  task automatic launch(input logic [3:0] op);
    opcode = op;
    start = 1'b1;
    step();
    start = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    // R1 and R10 at address 0
    chk("R1 uaddr after reset", 32'(uaddr), 32'd0);
    chk("R1 ovf after reset", 32'(stk_ovf), 32'd0);
    chk("R1 unf after reset", 32'(stk_unf), 32'd0);
    chk("R10 ctrl at fetch", 32'(ctrl), 32'h01);
    chk("R10 end at fetch", 32'(routine_end), 32'd0);

    // R2: opcode present but no start, address holds
    opcode = 4'd1;
    for (int i = 0; i < 3; i++) step();
    chk("R2 hold without start", 32'(uaddr), 32'd0);

    // vector table
    for (int v = 0; v < 7; v++) begin
      flag_z = VEC[v][43];
      flag_c = VEC[v][42];
      launch(VEC[v][47:44]);
      for (int k = 0; k < 7; k++) begin
        if (k != 0) step();
        chk($sformatf("R2-R7 vec %0d step %0d uaddr", v, k), 32'(uaddr),
            32'(VEC[v][41-6*k -: 6]));
      end
    end
    chk("R7 no stack errors after nesting", 32'({stk_ovf, stk_unf}), 32'd0);

    // R10 same-cycle control word and end marker
    flag_z = 1'b0;
    flag_c = 1'b0;
    launch(4'd1);
    chk("R10 ctrl at 4", 32'(ctrl), 32'h10);
    step();
    step();
    chk("R10 end at 6", 32'(routine_end), 32'd1);
    step();
    chk("R6 back to fetch", 32'(uaddr), 32'd0);

    // R9 underflow
    launch(4'd6);
    chk("R9 at return word", 32'(uaddr), 32'd24);
    chk("R9 unf before return", 32'(stk_unf), 32'd0);
    step();
    chk("R9 empty return goes to 0", 32'(uaddr), 32'd0);
    chk("R9 unf set", 32'(stk_unf), 32'd1);
    launch(4'd1);
    step();
    step();
    step();
    chk("R9 unf sticky", 32'(stk_unf), 32'd1);
    do_reset();
    chk("R1 reset clears unf", 32'(stk_unf), 32'd0);

    // R8 overflow: calls at 28 on clocks 2..5 push, clock 6 overflows
    launch(4'd7);
    for (int i = 0; i < 4; i++) step();
    chk("R8 no ovf with four pushes", 32'(stk_ovf), 32'd0);
    step();
    chk("R8 ovf on fifth call", 32'(stk_ovf), 32'd1);
    chk("R8 call still jumps", 32'(uaddr), 32'd28);
    step();
    step();
    chk("R8 ovf sticky", 32'(stk_ovf), 32'd1);
    do_reset();
    chk("R1 reset clears ovf", 32'(stk_ovf), 32'd0);

    // R7 stack usable after reset from a full state
    launch(4'd4);
    step();
    step();
    step();
    chk("R7 return after reset", 32'(uaddr), 32'd17);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog all-requirements act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule